// File: doc/BRIEF.md
# Byte-Addressed Data Memory

This block is the load/store memory that sits beside the execute stage of a 32-bit RISC core. The core presents one byte address per request along with an operation code: word load, word store, byte load or byte store. The block answers exactly one clock later with read data, a response strobe and an error flag. Storage is an internal array whose depth in words is a parameter. Each word is held as four separately writable 8-bit lanes, so a byte store changes one lane and leaves its three neighbours untouched.

Lanes are numbered big-endian: the byte at the lowest address of a word occupies the most significant eight bits of that word. Word accesses must fall on a four-byte boundary. A word request whose two low address bits are not zero is rejected. It is flagged as misaligned, writes nothing and returns zero data. Byte accesses are legal at every offset. A byte load returns the selected byte sign-extended to 32 bits.

Top module: `byte_data_mem`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `rsp_valid`, `rsp_misalign` and `rsp_rdata` are all zero.
- R2: `rsp_valid` is high in exactly those cycles that follow a clock edge at which `req_valid` was sampled high. `rsp_rdata` and `rsp_misalign` are zero whenever `rsp_valid` is low.
- R3: Op code 2'b00 is a word load and 2'b01 is a word store. An aligned word store writes all 32 bits, and a later aligned word load at that address returns them. The word is selected by address bits [IDX_W+1:2], where IDX_W = log2(DEPTH_WORDS). Higher address bits are ignored, so addresses that differ only in those bits reach the same word.
- R4: Lanes are big-endian. The byte at offset k (address bits [1:0] = k) of a word sits in bits [31-8k : 24-8k] of the word as written and read by word accesses.
- R5: Op code 2'b10 is a byte load. It returns the addressed byte in bits [7:0], and bits [31:8] are copies of bit 7.
- R6: Op code 2'b11 is a byte store. It writes `req_wdata[7:0]` into the addressed byte only, and the other three bytes of that word keep their values.
- R7: A word access (op bit 1 = 0) whose address bits [1:0] are not zero answers with `rsp_misalign` = 1 and `rsp_rdata` = 0. When it is a store, memory is left unchanged.
- R8: Byte accesses (op bit 1 = 1) never raise `rsp_misalign`, at any of the four offsets.
- R9: Stores answer with `rsp_rdata` = 0. An aligned store also answers with `rsp_misalign` = 0.
- R10: Words at byte addresses that differ by 4 are distinct storage: a store to one never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_op | input | 2 | Bit 0: store; bit 1: byte access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data; byte stores use bits [7:0] |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | DATA_W | Load result, zero for stores and errors |
| rsp_misalign | output | 1 | Word access with a non-zero byte offset |

## Verification
A behavioural byte-array model in the bench predicts every response. Directed patterns come first. Distinct per-word values tell apart index wrong-addressing and aliasing through the ignored upper address bits. A word holding 0x80 and 0x7F bytes separates sign extension from zero extension and shows whether the lane order is reversed. Byte stores at each offset, each followed by a word load, expose writes that reach neighbouring lanes. Misaligned word stores, each followed by an aligned load, show whether a rejected request still writes. A long stream of mixed random operations with back-to-back requests and idle gaps then checks store-to-load ordering and the response timing.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

   localparam int unsigned LANE_W = 8;

   typedef enum logic [1:0] {
      OP_LD_WORD = 2'b00,
      OP_ST_WORD = 2'b01,
      OP_LD_BYTE = 2'b10,
      OP_ST_BYTE = 2'b11
   } dmem_op_e;

   function automatic logic op_is_store(input logic [1:0] op);
      return op[0];
   endfunction

   function automatic logic op_is_byte(input logic [1:0] op);
      return op[1];
   endfunction

endpackage

// File: rtl/dmem_access_decode.sv
module dmem_access_decode
   import dmem_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned LANES       = 4,
   parameter int unsigned DEPTH_WORDS = 64,
   localparam int unsigned OFF_W      = $clog2(LANES),
   localparam int unsigned IDX_W      = $clog2(DEPTH_WORDS)
) (
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   output logic [IDX_W-1:0]  word_idx,
   output logic [OFF_W-1:0]  byte_off,
   output logic              misalign,
   output logic              rd_en,
   output logic [LANES-1:0]  lane_we
);

   logic store_ok;

   assign word_idx = req_addr[OFF_W +: IDX_W];
   assign byte_off = req_addr[OFF_W-1:0];
   assign misalign = req_valid && !op_is_byte(req_op) && (byte_off != '0);
   assign store_ok = req_valid && op_is_store(req_op) && !misalign;
   assign rd_en    = req_valid && !op_is_store(req_op) && !misalign;

   // lane l holds big-endian offset LANES-1-l
   for (genvar l = 0; l < LANES; l++) begin : g_lane_we
      localparam logic [OFF_W-1:0] LANE_OFF = OFF_W'(LANES - 1 - l);
      assign lane_we[l] = store_ok && (!op_is_byte(req_op) || (byte_off == LANE_OFF));
   end

endmodule

// File: rtl/dmem_lane_store.sv
module dmem_lane_store
   import dmem_pkg::*;
#(
   parameter int unsigned LANES       = 4,
   parameter int unsigned DEPTH_WORDS = 64,
   localparam int unsigned IDX_W      = $clog2(DEPTH_WORDS),
   localparam int unsigned WORD_W     = LANES * LANE_W
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  word_idx,
   input  logic [LANES-1:0]  lane_we,
   input  logic [WORD_W-1:0] lane_wdata,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_word
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH_WORDS];
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk) begin
         if (lane_we[l]) begin
            cells[word_idx] <= lane_wdata[l*LANE_W +: LANE_W];
         end
         if (rd_en) begin
            rd_q <= cells[word_idx];
         end
      end

      assign rd_word[l*LANE_W +: LANE_W] = rd_q;
   end

endmodule

// File: rtl/dmem_load_format.sv
module dmem_load_format
   import dmem_pkg::*;
#(
   parameter int unsigned LANES   = 4,
   localparam int unsigned OFF_W  = $clog2(LANES),
   localparam int unsigned WORD_W = LANES * LANE_W
) (
   input  logic [WORD_W-1:0] rd_word,
   input  logic              ld_word,
   input  logic              ld_byte,
   input  logic [OFF_W-1:0]  off,
   output logic [WORD_W-1:0] rdata
);

   logic [LANE_W-1:0] picked;

   always_comb begin
      picked = '0;
      for (int l = 0; l < LANES; l++) begin
         if (off == OFF_W'(LANES - 1 - l)) begin
            picked = rd_word[l*LANE_W +: LANE_W];
         end
      end
   end

   always_comb begin
      if (ld_word) begin
         rdata = rd_word;
      end else if (ld_byte) begin
         rdata = {{(WORD_W-LANE_W){picked[LANE_W-1]}}, picked};
      end else begin
         rdata = '0;
      end
   end

endmodule

// File: rtl/byte_data_mem.sv
module byte_data_mem
   import dmem_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned DEPTH_WORDS = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_misalign
);

   localparam int unsigned LANES = DATA_W / LANE_W;
   localparam int unsigned OFF_W = $clog2(LANES);
   localparam int unsigned IDX_W = $clog2(DEPTH_WORDS);

   if (DATA_W != 32) begin : g_bad_width
      $error("byte_data_mem: DATA_W must be 32");
   end
   if (DEPTH_WORDS < 2 || (DEPTH_WORDS & (DEPTH_WORDS - 1)) != 0) begin : g_bad_depth
      $error("byte_data_mem: DEPTH_WORDS must be a power of two of at least 2");
   end
   if (ADDR_W < IDX_W + OFF_W) begin : g_bad_addr
      $error("byte_data_mem: ADDR_W too narrow for DEPTH_WORDS");
   end

   logic [IDX_W-1:0]  word_idx;
   logic [OFF_W-1:0]  byte_off;
   logic              misalign;
   logic              rd_en;
   logic [LANES-1:0]  lane_we;
   logic [DATA_W-1:0] lane_wdata;
   logic [DATA_W-1:0] rd_word;

   logic              valid_q;
   logic              misalign_q;
   logic              ld_word_q;
   logic              ld_byte_q;
   logic [OFF_W-1:0]  off_q;

   dmem_access_decode #(
      .ADDR_W      (ADDR_W),
      .LANES       (LANES),
      .DEPTH_WORDS (DEPTH_WORDS)
   ) u_decode (
      .req_valid (req_valid),
      .req_op    (req_op),
      .req_addr  (req_addr),
      .word_idx  (word_idx),
      .byte_off  (byte_off),
      .misalign  (misalign),
      .rd_en     (rd_en),
      .lane_we   (lane_we)
   );

   // byte stores present the low byte on every lane; enables pick one
   assign lane_wdata = op_is_byte(req_op) ? {LANES{req_wdata[LANE_W-1:0]}} : req_wdata;

   dmem_lane_store #(
      .LANES       (LANES),
      .DEPTH_WORDS (DEPTH_WORDS)
   ) u_store (
      .clk        (clk),
      .word_idx   (word_idx),
      .lane_we    (lane_we),
      .lane_wdata (lane_wdata),
      .rd_en      (rd_en),
      .rd_word    (rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q    <= 1'b0;
         misalign_q <= 1'b0;
         ld_word_q  <= 1'b0;
         ld_byte_q  <= 1'b0;
         off_q      <= '0;
      end else begin
         valid_q    <= req_valid;
         misalign_q <= misalign;
         ld_word_q  <= rd_en && !op_is_byte(req_op);
         ld_byte_q  <= rd_en && op_is_byte(req_op);
         off_q      <= byte_off;
      end
   end

   dmem_load_format #(
      .LANES (LANES)
   ) u_format (
      .rd_word (rd_word),
      .ld_word (ld_word_q),
      .ld_byte (ld_byte_q),
      .off     (off_q),
      .rdata   (rsp_rdata)
   );

   assign rsp_valid    = valid_q;
   assign rsp_misalign = misalign_q;

endmodule

// File: rtl/dmem_checker.sv
module dmem_checker #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_op,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              rsp_misalign
);

   assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_rdata == '0 && !rsp_misalign));

   assert_misalign_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_op[1] && req_addr[1:0] != 2'b00) |=> (rsp_misalign && rsp_rdata == '0));

   assert_byte_never_misaligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op[1]) |=> !rsp_misalign);

   assert_byte_load_sign_extended_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'b10) |=> (rsp_rdata[DATA_W-1:8] == {(DATA_W-8){rsp_rdata[7]}}));

   assert_store_returns_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op[0]) |=> (rsp_rdata == '0));

endmodule

bind byte_data_mem dmem_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_dmem_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_op       (req_op),
   .req_addr     (req_addr),
   .rsp_valid    (rsp_valid),
   .rsp_rdata    (rsp_rdata),
   .rsp_misalign (rsp_misalign)
);

// File: tb/test_byte_data_mem.sv
module test_byte_data_mem;

   localparam int CLK_PERIOD  = 10;
   localparam int DEPTH_WORDS = 64;
   localparam int MEM_BYTES   = DEPTH_WORDS * 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [1:0]  req_op;
   logic [31:0] req_addr;
   logic [31:0] req_wdata;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        rsp_misalign;

   int checks = 0;
   int errors = 0;

   logic [7:0] model [MEM_BYTES];

   always #(CLK_PERIOD/2) clk = ~clk;

   byte_data_mem #(
      .ADDR_W      (32),
      .DATA_W      (32),
      .DEPTH_WORDS (DEPTH_WORDS)
   ) i_byte_data_mem (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_op       (req_op),
      .req_addr     (req_addr),
      .req_wdata    (req_wdata),
      .rsp_valid    (rsp_valid),
      .rsp_rdata    (rsp_rdata),
      .rsp_misalign (rsp_misalign)
   );

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // one request; outputs compared at the following falling edge
   task automatic access(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] wdata);
      int          idx  = int'(addr % MEM_BYTES);
      int          base = idx - (idx % 4);
      logic        emis = (op[1] == 1'b0) && (addr[1:0] != 2'b00);
      logic [31:0] edat = '0;
      string       tag;
      if (emis)       tag = "R7";
      else if (op == 2'b00) tag = "R3";
      else if (op == 2'b01) tag = "R9";
      else if (op == 2'b10) tag = "R5";
      else            tag = "R6";
      if (!emis) begin
         case (op)
            2'b00: edat = {model[base], model[base+1], model[base+2], model[base+3]};
            2'b01: for (int k = 0; k < 4; k++) model[base+k] = wdata[31-8*k -: 8];
            2'b10: edat = {{24{model[idx][7]}}, model[idx]};
            default: model[idx] = wdata[7:0];
         endcase
      end
      req_valid = 1'b1;
      req_op    = op;
      req_addr  = addr;
      req_wdata = wdata;
      @(negedge clk);
      req_valid = 1'b0;
      check("R2", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
      check(op[1] ? "R8" : tag, "rsp_misalign", {31'd0, rsp_misalign}, {31'd0, emis});
      check(tag, "rsp_rdata", rsp_rdata, edat);
   endtask

   task automatic idle();
      req_valid = 1'b0;
      @(negedge clk);
      check("R2", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
      check("R2", "idle rsp_rdata", rsp_rdata, 32'd0);
      check("R2", "idle rsp_misalign", {31'd0, rsp_misalign}, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < MEM_BYTES; i++) model[i] = 8'h00;
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_op    = 2'b00;
      req_addr  = '0;
      req_wdata = '0;
      repeat (3) begin
         @(negedge clk);
         check("R1", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
         check("R1", "reset rsp_rdata", rsp_rdata, 32'd0);
         check("R1", "reset rsp_misalign", {31'd0, rsp_misalign}, 32'd0);
      end
      rst_n = 1'b1;
      idle();

      // R3 / R10: clear the array, then distinct words at stride 4
      for (int w = 0; w < DEPTH_WORDS; w++) access(2'b01, 32'(w*4), 32'h0);
      for (int w = 0; w < 8; w++) access(2'b01, 32'(w*4), 32'hA5000000 + 32'(w*32'h01010101));
      for (int w = 0; w < 9; w++) access(2'b00, 32'(w*4), 32'h0);
      idle();

      // R4 / R5: lane order and sign extension
      access(2'b01, 32'h40, 32'h80FF017F);
      for (int k = 0; k < 4; k++) access(2'b10, 32'h40 + 32'(k), 32'h0);
      access(2'b00, 32'h40, 32'h0);

      // R6 / R8: byte stores at every offset, neighbours preserved
      for (int k = 0; k < 4; k++) begin
         access(2'b11, 32'h50 + 32'(k), 32'hFFFFFF00 | 32'(8'hC0 + k));
         access(2'b00, 32'h50, 32'h0);
      end
      access(2'b00, 32'h54, 32'h0);

      // R7: misaligned word store writes nothing; misaligned load errors
      access(2'b01, 32'h60, 32'h11223344);
      for (int k = 1; k < 4; k++) begin
         access(2'b01, 32'h60 + 32'(k), 32'hDEADBEEF);
         access(2'b00, 32'h60, 32'h0);
         access(2'b00, 32'h60 + 32'(k), 32'h0);
      end
      idle();

      // R3: upper address bits are ignored (aliasing)
      access(2'b01, 32'h70 + 32'(MEM_BYTES), 32'hCAFEF00D);
      access(2'b00, 32'h70, 32'h0);
      access(2'b10, 32'h72 + 32'(MEM_BYTES*3), 32'h0);
      access(2'b00, 32'h74, 32'h0);

      // mixed random traffic with idle gaps
      for (int n = 0; n < 600; n++) begin
         logic [1:0]  op = 2'($urandom % 4);
         logic [31:0] ad = 32'($urandom % (MEM_BYTES * 2));
         if ($urandom % 2 == 0) ad[1:0] = 2'b00;
         access(op, ad, $urandom);
         if ($urandom % 8 == 0) idle();
      end
      idle();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule